// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block moves one 8-bit byte at a time over a two-wire synchronous link in half-duplex fashion. One output pin always sources the shift clock, which runs at one twelfth of the system clock while an operation is in flight and rests high otherwise. The second pin is bidirectional and open-drain. During a transmit the block either pulls it low or lets it float, and an external pull-up supplies the high level. During a receive the block only listens to it.

A one-cycle write strobe with a byte starts a transmit. A receive starts whenever the receive-enable level is high and the receive-done flag is clear. Each operation shifts exactly eight bits, least significant bit first. Outgoing data changes while the shift clock is low. Incoming data is captured at the system-clock edge on which the shift clock rises. When the eighth bit finishes, the matching done flag is set. Software clears it with a one-cycle clear strobe.

Top module: `sync_shift_port`

## Requirements
- R1: While no operation is active, sclk_o is held at 1 and produces no pulses.
- R2: During an operation every bit lasts 12 system clocks: sclk_o is 0 for the first 6 and 1 for the last 6. An operation therefore produces exactly 8 rising edges of sclk_o.
- R3: On transmit, bit k of the written byte (k = 0 first) is on the data pin at rising edge k+1 of sclk_o. A 0 bit means data_pd_o = 1 (pull low) and a 1 bit means data_pd_o = 0 (release).
- R4: data_pd_o is 0 whenever no transmit is active, including during a receive.
- R5: A write strobe wr_i while idle starts a transmit at the next clock edge, and busy_o rises.
- R6: tx_done_o becomes 1 exactly 96 cycles after the edge that accepted the write. At that same point busy_o falls.
- R7: When rx_en_i is 1 and rx_done_o is 0 while idle, a receive starts. data_i is sampled at each rising edge of sclk_o, LSB first. After 96 cycles rx_byte_o holds the byte and rx_done_o is 1.
- R8: While rx_done_o is 1, no new receive starts, even if rx_en_i stays 1.
- R9: A write strobe while an operation is active is ignored: the transmitted bits are unchanged.
- R10: A one-cycle pulse on tx_done_clr_i or rx_done_clr_i clears the matching flag at the next edge.
- R11: After reset, busy_o, tx_done_o, rx_done_o and data_pd_o are 0, sclk_o is 1 and rx_byte_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Transmit write strobe |
| wr_byte_i | input | 8 | Byte to transmit |
| rx_en_i | input | 1 | Receive enable level |
| tx_done_clr_i | input | 1 | Clears tx_done_o |
| rx_done_clr_i | input | 1 | Clears rx_done_o |
| data_i | input | 1 | Sensed level of the data pin |
| data_pd_o | output | 1 | Pull-down enable for the open-drain data pin |
| sclk_o | output | 1 | Shift clock pin |
| busy_o | output | 1 | An operation is in flight |
| tx_done_o | output | 1 | Transmit complete flag |
| rx_done_o | output | 1 | Receive complete flag |
| rx_byte_o | output | 8 | Last received byte |

## Verification
A divider phase that slips shows up within one bit period, as a low or high run of sclk_o that is not 6 cycles long, or as a wrong number of rising edges. A wrong bit counter or shift direction shows up on the data pin at the first rising edge whose bit differs, or in rx_byte_o at the end of that same operation. A wrong flag or start condition shows up at the 96-cycle completion point, or as clock pulses appearing while idle. Sweeping all 256 byte values in both directions exposes every bit position at both pin levels.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned SSP_DIV   = 12;
  localparam int unsigned SSP_NBITS = 8;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_TX   = 2'd1,
    OP_RX   = 2'd2
  } ssp_op_e;
endpackage

// File: rtl/ssp_clkdiv.sv
module ssp_clkdiv #(
  parameter int unsigned DIV = ssp_pkg::SSP_DIV
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_stb_o,
  output logic end_stb_o
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned CW   = $clog2(DIV);
  localparam logic [CW-1:0] LAST  = CW'(DIV - 1);
  localparam logic [CW-1:0] PRE_R = CW'(HALF - 1);
  localparam logic [CW-1:0] HALFV = CW'(HALF);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!run_i || cnt_q == LAST) cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  assign sclk_o     = !(run_i && cnt_q < HALFV);
  assign rise_stb_o = run_i && cnt_q == PRE_R;
  assign end_stb_o  = run_i && cnt_q == LAST;

  // R2
  low_run_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) && $fell(sclk_o) |-> $past(cnt_q) == LAST);
  // R2
  high_run_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $rose(sclk_o) |-> cnt_q == HALFV);
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int unsigned NBITS = ssp_pkg::SSP_NBITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [NBITS-1:0] load_val_i,
  input  logic             shift_out_i,
  input  logic             shift_in_i,
  input  logic             in_bit_i,
  input  logic             bit_end_i,
  output logic [NBITS-1:0] q_o,
  output logic             last_o
);
  localparam int unsigned BW = $clog2(NBITS);
  localparam logic [BW-1:0] LASTB = BW'(NBITS - 1);

  logic [NBITS-1:0] sh_q;
  logic [BW-1:0]    bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sh_q <= '0;
    else if (load_i)      sh_q <= load_val_i;
    else if (shift_in_i)  sh_q <= {in_bit_i, sh_q[NBITS-1:1]};
    else if (shift_out_i) sh_q <= {1'b1, sh_q[NBITS-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        bit_q <= '0;
    else if (load_i)    bit_q <= '0;
    else if (bit_end_i) bit_q <= bit_q + 1'b1;
  end

  assign q_o    = sh_q;
  assign last_o = bit_q == LASTB;
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import ssp_pkg::*;
#(
  parameter int unsigned DIV   = SSP_DIV,
  parameter int unsigned NBITS = SSP_NBITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [NBITS-1:0] wr_byte_i,
  input  logic             rx_en_i,
  input  logic             tx_done_clr_i,
  input  logic             rx_done_clr_i,
  input  logic             data_i,
  output logic             data_pd_o,
  output logic             sclk_o,
  output logic             busy_o,
  output logic             tx_done_o,
  output logic             rx_done_o,
  output logic [NBITS-1:0] rx_byte_o
);
  ssp_op_e          op_q;
  logic             run, rise_stb, end_stb, last_bit, finish;
  logic             start_tx, start_rx;
  logic [NBITS-1:0] sh_q;
  logic             tx_done_q, rx_done_q;
  logic [NBITS-1:0] rx_byte_q;

  assign run      = op_q != OP_IDLE;
  assign start_tx = !run && wr_i;
  assign start_rx = !run && !wr_i && rx_en_i && !rx_done_q;
  assign finish   = end_stb && last_bit;

  ssp_clkdiv #(.DIV(DIV)) u_div (
    .clk_i, .rst_ni,
    .run_i      (run),
    .sclk_o     (sclk_o),
    .rise_stb_o (rise_stb),
    .end_stb_o  (end_stb)
  );

  ssp_shifter #(.NBITS(NBITS)) u_sh (
    .clk_i, .rst_ni,
    .load_i      (start_tx || start_rx),
    .load_val_i  (start_tx ? wr_byte_i : '0),
    .shift_out_i (op_q == OP_TX && end_stb),
    .shift_in_i  (op_q == OP_RX && rise_stb),
    .in_bit_i    (data_i),
    .bit_end_i   (end_stb),
    .q_o         (sh_q),
    .last_o      (last_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       op_q <= OP_IDLE;
    else if (start_tx) op_q <= OP_TX;
    else if (start_rx) op_q <= OP_RX;
    else if (finish)   op_q <= OP_IDLE;
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_done_q <= 1'b0;
      rx_done_q <= 1'b0;
      rx_byte_q <= '0;
    end else begin
      if (finish && op_q == OP_TX) tx_done_q <= 1'b1;
      else if (tx_done_clr_i)      tx_done_q <= 1'b0;
      if (finish && op_q == OP_RX) begin
        rx_done_q <= 1'b1;
        rx_byte_q <= sh_q;
      end else if (rx_done_clr_i) begin
        rx_done_q <= 1'b0;
      end
    end
  end

  assign data_pd_o = op_q == OP_TX && !sh_q[0];
  assign busy_o    = run;
  assign tx_done_o = tx_done_q;
  assign rx_done_o = rx_done_q;
  assign rx_byte_o = rx_byte_q;

  // R1
  idle_clk_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sclk_o);
  // R4
  rx_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_q == OP_RX |-> !data_pd_o);
  // R8
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_q && !run && !rx_done_clr_i |=> op_q != OP_RX);
  // R6
  tx_flag_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_done_q) |-> $past(op_q) == OP_TX && !busy_o);
  // R9
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && wr_i && !finish |=> $stable(op_q));
endmodule

// File: tb/sim_sync_shift_port.sv
module sim_sync_shift_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wr_byte = '0;
  logic       rx_en = 1'b0;
  logic       tx_clr = 1'b0;
  logic       rx_clr = 1'b0;
  logic       slave_bit = 1'b1;
  logic       pd, sclk, busy, tx_done, rx_done;
  logic [7:0] rx_byte;
  logic       pin;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         ended = 1'b0;

  always #10 clk = ~clk;

  // wired-AND of open-drain pull-down, external pull-up and remote driver
  assign pin = slave_bit & ~pd;

  sync_shift_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_byte_i(wr_byte),
    .rx_en_i(rx_en), .tx_done_clr_i(tx_clr), .rx_done_clr_i(rx_clr),
    .data_i(pin), .data_pd_o(pd), .sclk_o(sclk), .busy_o(busy),
    .tx_done_o(tx_done), .rx_done_o(rx_done), .rx_byte_o(rx_byte)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // transmit one byte; optional stray write at cycle 10 (R9)
  task automatic do_tx(input logic [7:0] b, input bit stray);
    logic [7:0] got;
    int rises, lows, highs;
    logic prev;
    got = '0; rises = 0; lows = 0; highs = 0;
    wr = 1'b1; wr_byte = b;
    @(negedge clk);
    wr = 1'b0;
    prev = 1'b1;
    for (int c = 1; c <= 96; c++) begin
      if (c > 1) @(negedge clk);
      if (stray && c == 10) begin wr = 1'b1; wr_byte = ~b; end
      if (stray && c == 11) wr = 1'b0;
      if (c == 1) chk(busy === 1'b1, "R5 busy after write", busy, 1);
      if (sclk) highs++; else lows++;
      if (!prev && sclk) begin
        if (rises < 8) got[rises] = pin;
        rises++;
      end
      prev = sclk;
    end
    chk(tx_done === 1'b0, "R6 tx_done before 96", tx_done, 0);
    chk(lows == 48 && highs == 48, "R2 low/high cycles", lows, 48);
    chk(rises == 8, "R2 rising edges", rises, 8);
    chk(got == b, stray ? "R9 stray write ignored" : "R3 tx bits", got, b);
    @(negedge clk);
    chk(tx_done === 1'b1 && busy === 1'b0, "R6 tx_done at 96", {tx_done, busy}, 2);
    chk(pd === 1'b0 && sclk === 1'b1, "R4 R1 idle after tx", {pd, sclk}, 1);
    tx_clr = 1'b1;
    @(negedge clk);
    tx_clr = 1'b0;
    chk(tx_done === 1'b0, "R10 tx_done cleared", tx_done, 0);
  endtask

  task automatic do_rx(input logic [7:0] b, input bit hold_wait);
    int idx, pd_seen, rises;
    logic prev;
    idx = 0; pd_seen = 0; rises = 0;
    rx_en = 1'b1;
    prev = 1'b1;
    for (int c = 1; c <= 96; c++) begin
      @(negedge clk);
      if (pd) pd_seen++;
      if (prev && !sclk) begin
        slave_bit = b[idx[2:0]];
        idx++;
      end
      if (!prev && sclk) rises++;
      prev = sclk;
    end
    chk(rx_done === 1'b0, "R7 rx_done before 96", rx_done, 0);
    chk(pd_seen == 0, "R4 no pull during rx", pd_seen, 0);
    chk(rises == 8, "R2 rx rising edges", rises, 8);
    @(negedge clk);
    slave_bit = 1'b1;
    chk(rx_done === 1'b1 && rx_byte === b, "R7 rx byte", rx_byte, b);
    if (hold_wait) begin
      int pulses;
      pulses = 0;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        if (busy || !sclk) pulses++;
      end
      chk(pulses == 0, "R8 R1 no rx restart while done", pulses, 0);
    end
    rx_en = 1'b0;
    rx_clr = 1'b1;
    @(negedge clk);
    rx_clr = 1'b0;
    chk(rx_done === 1'b0 && busy === 1'b0, "R10 rx_done cleared", {rx_done, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 0 && tx_done === 0 && rx_done === 0 && pd === 0 && sclk === 1
        && rx_byte === 8'h00, "R11 reset state", {busy, tx_done, rx_done, pd, sclk}, 1);
    rst_n = 1'b1;
    begin
      int pulses;
      pulses = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (!sclk || busy) pulses++;
      end
      chk(pulses == 0, "R1 idle no pulses", pulses, 0);
    end
    for (int v = 0; v < 256; v++) do_tx(8'(v), 1'b0);
    do_tx(8'hA5, 1'b1);
    do_tx(8'h3C, 1'b1);
    for (int v = 0; v < 256; v++) do_rx(8'(v), v[4:0] == 5'd0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end
endmodule